// File: doc/BRIEF.md
# Registered Integer ALU with Bitwise-Invert and Magnitude Operations

This block is a two's-complement arithmetic and logic unit for W-bit operands `a_i` and `b_i`. A 3-bit operation code picks one of seven operations: bitwise AND, bitwise OR, add, subtract, signed set-less-than, bitwise invert of `b_i`, and magnitude (absolute value) of `b_i`. The magnitude operation does not have its own negator. A decoded magnitude-mode bit steers `b_i` into the shared adder. There, `a_i` is forced to zero and `b_i` is inverted with a carry-in of one whenever its sign bit is set.

The block computes its result, zero flag and overflow flag in one combinational pass. All three are captured in output registers, so the values that are present before a rising clock edge appear on the outputs just after that edge. A synchronous active-high reset clears the registers. The most negative operand has no positive counterpart. For that input the magnitude operation returns the same bit pattern and raises the overflow flag.

Top module: `alu_cabs`

## Requirements
- R1: Code 000 gives the bitwise AND of `a_i` and `b_i`, and code 001 gives the bitwise OR.
- R2: Code 010 gives `a_i + b_i` modulo 2^W. `ovf_o` is 1 exactly when the signed sum falls outside the W-bit two's-complement range.
- R3: Code 110 gives `a_i - b_i` modulo 2^W. `ovf_o` is 1 exactly when the signed difference falls outside the W-bit two's-complement range.
- R4: Code 111 gives 1 when `a_i` is less than `b_i` as signed numbers and 0 otherwise, with all upper bits at 0.
- R5: Code 100 gives the bitwise complement of `b_i`, and `a_i` has no effect on it.
- R6: Code 101 gives `b_i` when its top bit is 0 and the two's-complement negation of `b_i` otherwise, and `a_i` has no effect on it.
- R7: Under code 101, when `b_i` is a 1 followed by W-1 zeros, the result is that same pattern and `ovf_o` is 1. For every other `b_i`, `ovf_o` is 0 under code 101.
- R8: Under codes 000, 001, 011, 100 and 111, `ovf_o` is 0.
- R9: `zero_o` is 1 exactly when every bit of `res_o` is 0.
- R10: Code 011 is unused and gives a result of 0.
- R11: The outputs register the inputs that are present at a rising clock edge. While `rst` is high at an edge, the outputs become `res_o` = 0, `zero_o` = 1 and `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand, the sole operand of the unary operations |
| res_o | output | W | Registered result |
| zero_o | output | 1 | Registered all-zero flag of the result |
| ovf_o | output | 1 | Registered overflow flag |

## Verification
Each result and both flags are due exactly one rising edge after the inputs that produce them, because the only storage is the output register stage. The driver sets the operands on a falling edge and pushes the expected triple into a queue. The monitor samples a quarter period after the next rising edge and pops one item for each vector. Every comparison therefore lands on the single cycle in which that vector's result is valid. The reset values are sampled in the same way, after an edge with `rst` high.

// File: rtl/alu_cabs_pkg.sv
package alu_cabs_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_RSV  = 3'b011,
    OP_NOTB = 3'b100,
    OP_ABSB = 3'b101,
    OP_SUB  = 3'b110,
    OP_SLT  = 3'b111
  } alu_op_e;

  typedef enum logic [2:0] {
    SEL_AND,
    SEL_OR,
    SEL_SUM,
    SEL_SLT,
    SEL_NOTB,
    SEL_NONE
  } res_sel_e;

  typedef struct packed {
    logic     b_inv;     // invert b into the adder
    logic     carry_in;  // adder carry-in
    logic     a_zero;    // force adder a input to zero
    logic     abs_mode;  // magnitude control: negation follows b sign
    logic     ovf_en;    // signed overflow reported for add/sub
    res_sel_e sel;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_cabs_dec.sv
module alu_cabs_dec
  import alu_cabs_pkg::*;
(
  input  logic [2:0] op_i,
  output alu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '{b_inv: 1'b0, carry_in: 1'b0, a_zero: 1'b0,
               abs_mode: 1'b0, ovf_en: 1'b0, sel: SEL_NONE};
    unique case (alu_op_e'(op_i))
      OP_AND:  ctrl_o.sel = SEL_AND;
      OP_OR:   ctrl_o.sel = SEL_OR;
      OP_ADD: begin
        ctrl_o.sel    = SEL_SUM;
        ctrl_o.ovf_en = 1'b1;
      end
      OP_SUB: begin
        ctrl_o.sel      = SEL_SUM;
        ctrl_o.b_inv    = 1'b1;
        ctrl_o.carry_in = 1'b1;
        ctrl_o.ovf_en   = 1'b1;
      end
      OP_SLT: begin
        ctrl_o.sel      = SEL_SLT;
        ctrl_o.b_inv    = 1'b1;
        ctrl_o.carry_in = 1'b1;
      end
      OP_NOTB: ctrl_o.sel = SEL_NOTB;
      OP_ABSB: begin
        ctrl_o.sel      = SEL_SUM;
        ctrl_o.a_zero   = 1'b1;
        ctrl_o.abs_mode = 1'b1;
      end
      default: ctrl_o.sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/alu_cabs_addsub.sv
module alu_cabs_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         a_zero_i,
  input  logic         b_inv_i,
  input  logic         cin_i,
  input  logic         abs_mode_i,
  output logic [W-1:0] sum_o,
  output logic         sovf_o,
  output logic         less_o,
  output logic         abs_ovf_o
);

  localparam int MSB = W - 1;

  logic         neg_b;
  logic         cin_eff;
  logic [W-1:0] a_eff;
  logic [W-1:0] b_eff;

  always_comb begin
    // magnitude mode: negate b only when it is negative
    neg_b   = abs_mode_i ? b_i[MSB] : b_inv_i;
    cin_eff = abs_mode_i ? b_i[MSB] : cin_i;
    a_eff   = a_zero_i ? '0 : a_i;
    b_eff   = neg_b ? ~b_i : b_i;
    sum_o   = a_eff + b_eff + {{(W-1){1'b0}}, cin_eff};
    sovf_o  = (a_eff[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_eff[MSB]);
    less_o  = sum_o[MSB] ^ sovf_o;
    // 0 - b leaves the sign set only for the most negative b
    abs_ovf_o = abs_mode_i & sum_o[MSB];
  end

endmodule

// File: rtl/alu_cabs_resmux.sv
module alu_cabs_resmux
  import alu_cabs_pkg::*;
#(
  parameter int W = 8
) (
  input  res_sel_e     sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] sum_i,
  input  logic         less_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);

  logic [W-1:0] or_chain;

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_i & b_i;
      SEL_OR:   res_o = a_i | b_i;
      SEL_SUM:  res_o = sum_i;
      SEL_SLT:  res_o = {{(W-1){1'b0}}, less_i};
      SEL_NOTB: res_o = ~b_i;
      default:  res_o = '0;
    endcase
  end

  // ripple OR chain for the zero detect
  assign or_chain[0] = res_o[0];
  for (genvar g = 1; g < W; g++) begin : g_zor
    assign or_chain[g] = or_chain[g-1] | res_o[g];
  end
  assign zero_o = ~or_chain[W-1];

endmodule

// File: rtl/alu_cabs.sv
module alu_cabs
  import alu_cabs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         ovf_o
);

  alu_ctrl_t    ctrl;
  logic [W-1:0] sum;
  logic         sovf;
  logic         less;
  logic         abs_ovf;
  logic [W-1:0] res_d;
  logic         zero_d;
  logic         ovf_d;

  alu_cabs_dec u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  alu_cabs_addsub #(.W(W)) u_addsub (
    .a_i        (a_i),
    .b_i        (b_i),
    .a_zero_i   (ctrl.a_zero),
    .b_inv_i    (ctrl.b_inv),
    .cin_i      (ctrl.carry_in),
    .abs_mode_i (ctrl.abs_mode),
    .sum_o      (sum),
    .sovf_o     (sovf),
    .less_o     (less),
    .abs_ovf_o  (abs_ovf)
  );

  alu_cabs_resmux #(.W(W)) u_mux (
    .sel_i  (ctrl.sel),
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_i  (sum),
    .less_i (less),
    .res_o  (res_d),
    .zero_o (zero_d)
  );

  assign ovf_d = (ctrl.ovf_en & sovf) | abs_ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      zero_o <= 1'b1;
      ovf_o  <= 1'b0;
    end else begin
      res_o  <= res_d;
      zero_o <= zero_d;
      ovf_o  <= ovf_d;
    end
  end

endmodule

// File: rtl/alu_cabs_chk.sv
module alu_cabs_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o,
  input logic         zero_o,
  input logic         ovf_o
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (res_o == '0) && zero_o && !ovf_o);

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    zero_o == (res_o == '0));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(op_i == 3'b010 || op_i == 3'b110 || op_i == 3'b101) |=> !ovf_o);

  // R5
  invert_b_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b100) |=> res_o == ~$past(b_i));

  // R4
  slt_width_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b111) |=> res_o[W-1:1] == '0);

  // R6
  abs_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b101) |=> (!res_o[W-1] || ovf_o));

  // R7
  abs_corner_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b101 && b_i == MOST_NEG) |=> ovf_o && res_o == MOST_NEG);

  // R10
  unused_code_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'b011) |=> res_o == '0);

endmodule

bind alu_cabs alu_cabs_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_i   (op_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .res_o  (res_o),
  .zero_o (zero_o),
  .ovf_o  (ovf_o)
);

// File: tb/test_alu_cabs.sv
`timescale 1ns/1ps
module test_alu_cabs;

  localparam int N    = 8;
  localparam int MAXP = (1 << (N-1)) - 1;
  localparam int MINN = -(1 << (N-1));

  typedef struct packed {
    logic [2:0]   op;
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic [N-1:0] res;
    logic         zero;
    logic         ovf;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op  = 3'b000;
  logic [N-1:0] a   = '0;
  logic [N-1:0] b   = '0;
  logic [N-1:0] res;
  logic         zero;
  logic         ovf;

  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  exp_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  alu_cabs #(.W(N)) i_alu_cabs (
    .clk    (clk),
    .rst    (rst),
    .op_i   (op),
    .a_i    (a),
    .b_i    (b),
    .res_o  (res),
    .zero_o (zero),
    .ovf_o  (ovf)
  );

  function automatic exp_t model(logic [2:0] o, logic [N-1:0] x, logic [N-1:0] y);
    exp_t e;
    int sx, sy, s;
    sx = int'($signed(x));
    sy = int'($signed(y));
    e.op = o; e.a = x; e.b = y; e.ovf = 1'b0; e.res = '0;
    case (o)
      3'b000: e.res = x & y;
      3'b001: e.res = x | y;
      3'b010: begin s = sx + sy; e.res = s[N-1:0]; e.ovf = (s > MAXP) || (s < MINN); end
      3'b110: begin s = sx - sy; e.res = s[N-1:0]; e.ovf = (s > MAXP) || (s < MINN); end
      3'b111: e.res = (sx < sy) ? N'(1) : '0;
      3'b100: e.res = ~y;
      3'b101: begin
        s = (sy < 0) ? -sy : sy;
        e.res = s[N-1:0];
        e.ovf = (s > MAXP);
      end
      default: e.res = '0;
    endcase
    e.zero = (e.res == '0);
    return e;
  endfunction

  function automatic string tag_of(logic [2:0] o, logic [N-1:0] y);
    case (o)
      3'b000, 3'b001: return "R1";
      3'b010: return "R2";
      3'b110: return "R3";
      3'b111: return "R4";
      3'b100: return "R5";
      3'b101: return (y == {1'b1, {(N-1){1'b0}}}) ? "R7" : "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [2:0] o, input logic [N-1:0] x, input logic [N-1:0] y);
    @(negedge clk);
    op = o; a = x; b = y;
    sb_q.push_back(model(o, x, y));
  endtask

  // monitor: result of the vector driven at the previous falling edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_vec++;
        if (res !== e.res) begin
          n_fail++;
          $display("FAIL %s op=%b a=%h b=%h res actual=%h expected=%h",
                   tag_of(e.op, e.b), e.op, e.a, e.b, res, e.res);
        end
        if (zero !== e.zero) begin
          n_fail++;
          $display("FAIL R9 op=%b a=%h b=%h zero actual=%b expected=%b",
                   e.op, e.a, e.b, zero, e.zero);
        end
        if (ovf !== e.ovf) begin
          n_fail++;
          $display("FAIL %s op=%b a=%h b=%h ovf actual=%b expected=%b",
                   (e.op inside {3'b010, 3'b110, 3'b101}) ? tag_of(e.op, e.b) : "R8",
                   e.op, e.a, e.b, ovf, e.ovf);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] corner [5];
    logic [2:0]   ops    [8];
    corner = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    ops    = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111};

    // R11: reset state, sampled after edges with rst high
    a = 8'h5A; b = 8'hA5; op = 3'b010;
    repeat (3) @(posedge clk);
    #5;
    n_vec++;
    if (res !== '0 || zero !== 1'b1 || ovf !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset actual=%h/%b/%b expected=00/1/0", res, zero, ovf);
    end
    @(negedge clk);
    rst = 1'b0;

    // corner pairs for every code
    foreach (ops[i])
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++)
          apply(ops[i], corner[x], corner[y]);

    // unary codes: every b, with a varying to show a has no effect (R5, R6, R7)
    for (int y = 0; y < (1 << N); y++) begin
      apply(3'b100, N'(y * 37 + 11), N'(y));
      apply(3'b101, N'(y * 53 + 7), N'(y));
    end

    // binary codes: strided sweep over the operand space (R1 R2 R3 R4 R10)
    foreach (ops[i])
      if (ops[i] != 3'b100 && ops[i] != 3'b101)
        for (int x = 0; x < (1 << N); x += 5)
          for (int y = 0; y < (1 << N); y += 3)
            apply(ops[i], N'(x), N'(y));

    // R11: reset applied again mid-run
    @(negedge clk);
    op = 3'b010; a = 8'h7F; b = 8'h7F; rst = 1'b1;
    wait (sb_q.size() == 0);
    @(posedge clk);
    #5;
    n_vec++;
    if (res !== '0 || zero !== 1'b1 || ovf !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 mid-run reset actual=%h/%b/%b expected=00/1/0", res, zero, ovf);
    end
    @(negedge clk);
    rst = 1'b0;
    apply(3'b010, 8'h7F, 8'h01);  // R2 overflow right after reset
    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule